// File: doc/BRIEF.md
# DMA Interrupt and Channel Start Control

This block holds the interrupt control word of a multi-channel DMA controller together with the per-channel control words and the primary enable word. It decides, on every register write and every transfer-completion report, whether a DMA interrupt is due. It raises a single-cycle request toward bit 3 of the system interrupt status only when that condition newly appears. It also issues a one-cycle start pulse to a channel's transfer engine when that channel is armed and enabled. The transfer engines sit outside the block and report completion back through one input per channel.

All registers are written as whole 32-bit words through a simple write strobe with an address offset. The stored words are visible on output ports so that neighbouring logic, and a register read path elsewhere, can observe them. Every output is registered and changes at the clock edge that samples the write or the completion report.

Top module: `dmaic_top`

## Requirements
- R1: After synchronous reset every output is 0: the interrupt control word, the enable word, all channel control words, the interrupt request and all start pulses.
- R2: A write to offset 0x0F4 loads bits 0-5, 15 and 16-23 of the interrupt control word from the written value; bits 6-14 always read 0.
- R3: In the same write, flag bits 24-30 are cleared where the written bit is 1 and keep their old value where it is 0.
- R4: A completion report on `done_i[n]` sets flag bit 24+n only when enable bit 16+n of the interrupt control word (after any write in the same cycle) is 1; a write can never set a flag.
- R5: The interrupt is due when bit 15 (bus error) is 1, or when bit 23 (global enable) is 1 and any of bits 24-30 is 1. Bit 31 (already-sent) equals the due condition after every update.
- R6: `irq_req_o` pulses high for exactly one cycle when bit 31 goes from 0 to 1, and stays low while bit 31 was already 1.
- R7: A write to offset 0x088 + 0x10*n stores the word in channel n's control register; if bit 24 of that word is 1 and bit 3+4n of the enable word is 1, `ch_start_o[n]` pulses for one cycle, in the cycle after the write.
- R8: A channel control write with bit 24 clear, or with enable bit 3+4n clear, produces no start pulse on any channel.
- R9: A completion report on `done_i[n]` clears bit 24 of channel n's control register unless that register is written in the same cycle.
- R10: A write to offset 0x0F0 loads the whole enable word; writes to any other offset change no state and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | ADDR_W | Register offset of the write |
| wr_data | input | 32 | Write data |
| done_i | input | NUM_CH | Per-channel transfer completion report |
| irq_ctrl_o | output | 32 | Interrupt control word |
| irq_req_o | output | 1 | One-cycle request to set interrupt status bit 3 |
| enable_o | output | 32 | Primary enable word |
| ch_start_o | output | NUM_CH | One-cycle start pulse per channel |
| chan_ctrl_o | output | NUM_CH*32 | Channel control words, channel n at bits 32n+31:32n |

## Verification
The assertions watch on every cycle that the already-sent bit matches the due condition, that a request only accompanies a 0-to-1 change of that bit, that a start pulse always traces back to an armed write on an enabled channel, that a flag only rises from an enabled completion report, and that a completion report drops the channel's armed bit. The bench's scenarios are needed to show the masked load of the control word, the full sweep of write-one-to-clear patterns over all seven flags, the gating of each channel's start by its own enable bit, and that writes to unmapped offsets leave every word untouched.

// File: rtl/dmaic_pkg.sv
package dmaic_pkg;

    localparam int unsigned MAX_CH     = 7;
    localparam int unsigned WORD_W     = 32;

    // Bit positions inside the interrupt control word
    localparam int unsigned BERR_BIT   = 15;
    localparam int unsigned GEN_BIT    = 23;
    localparam int unsigned SENT_BIT   = 31;
    localparam int unsigned FLAG_LSB   = 24;
    localparam int unsigned IEN_LSB    = 16;

    // Bit positions in channel control and enable words
    localparam int unsigned ARM_BIT    = 24;
    localparam int unsigned CHEN_LSB   = 3;
    localparam int unsigned CHEN_STEP  = 4;

    localparam logic [WORD_W-1:0] CTRL_LOAD_MASK = 32'h00FF_803F;
    localparam logic [WORD_W-1:0] CTRL_FLAG_MASK = 32'h7F00_0000;

    // Register offsets
    localparam logic [11:0] OFS_CTRL   = 12'h0F4;
    localparam logic [11:0] OFS_ENABLE = 12'h0F0;
    localparam logic [11:0] OFS_CHAN0  = 12'h088;
    localparam logic [11:0] OFS_STRIDE = 12'h010;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              req;
    } irq_next_t;

    function automatic logic [11:0] chan_ofs(input int unsigned n);
        return OFS_CHAN0 + 12'(n * 16);
    endfunction

    function automatic logic irq_due(input logic [WORD_W-1:0] w);
        return (w[GEN_BIT] && (|w[30:24])) || w[BERR_BIT];
    endfunction

endpackage

// File: rtl/dmaic_wr_decode.sv
module dmaic_wr_decode
    import dmaic_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ADDR_W = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hit_ctrl,
    output logic              hit_enable,
    output logic [NUM_CH-1:0] hit_chan
);

    assign hit_ctrl   = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    assign hit_enable = wr_en && (wr_addr == ADDR_W'(OFS_ENABLE));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
        assign hit_chan[n] = wr_en && (wr_addr == ADDR_W'(chan_ofs(n)));
    end

endmodule

// File: rtl/dmaic_irq_reg.sv
module dmaic_irq_reg
    import dmaic_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [31:0]       wr_data,
    input  logic [NUM_CH-1:0] done_i,
    output logic [31:0]       ctrl_q,
    output logic              req_q
);

    irq_next_t   nxt;
    logic [31:0] base;
    logic [31:0] set_bits;
    logic        due;

    always_comb begin
        if (wr_hit) begin
            base = (wr_data & CTRL_LOAD_MASK) | (ctrl_q & ~wr_data & CTRL_FLAG_MASK);
        end else begin
            base = ctrl_q;
        end
        set_bits = '0;
        set_bits[FLAG_LSB +: NUM_CH] = done_i & base[IEN_LSB +: NUM_CH];
        nxt.word = base | set_bits;
        due      = irq_due(nxt.word);
        nxt.word[SENT_BIT] = due;
        nxt.req  = due && !ctrl_q[SENT_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            req_q  <= 1'b0;
        end else begin
            ctrl_q <= nxt.word;
            req_q  <= nxt.req;
        end
    end

endmodule

// File: rtl/dmaic_chan_slot.sv
module dmaic_chan_slot
    import dmaic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic [31:0] wr_data,
    input  logic        en_bit,
    input  logic        done,
    output logic        start_o,
    output logic [31:0] ctrl_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o  <= '0;
            start_o <= 1'b0;
        end else begin
            start_o <= wr_hit && wr_data[ARM_BIT] && en_bit;
            if (wr_hit) begin
                ctrl_o <= wr_data;
            end else if (done) begin
                ctrl_o[ARM_BIT] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dmaic_top.sv
module dmaic_top
    import dmaic_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [NUM_CH-1:0]    done_i,
    output logic [31:0]          irq_ctrl_o,
    output logic                 irq_req_o,
    output logic [31:0]          enable_o,
    output logic [NUM_CH-1:0]    ch_start_o,
    output logic [NUM_CH*32-1:0] chan_ctrl_o
);

    logic              hit_ctrl;
    logic              hit_enable;
    logic [NUM_CH-1:0] hit_chan;

    dmaic_wr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .hit_ctrl   (hit_ctrl),
        .hit_enable (hit_enable),
        .hit_chan   (hit_chan)
    );

    dmaic_irq_reg #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (hit_ctrl),
        .wr_data (wr_data),
        .done_i  (done_i),
        .ctrl_q  (irq_ctrl_o),
        .req_q   (irq_req_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_o <= '0;
        end else if (hit_enable) begin
            enable_o <= wr_data;
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        dmaic_chan_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (hit_chan[n]),
            .wr_data (wr_data),
            .en_bit  (enable_o[CHEN_LSB + CHEN_STEP*n]),
            .done    (done_i[n]),
            .start_o (ch_start_o[n]),
            .ctrl_o  (chan_ctrl_o[n*32 +: 32])
        );
    end

endmodule

// File: rtl/dmaic_checker.sv
module dmaic_checker
    import dmaic_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ADDR_W = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [31:0]          wr_data,
    input logic [NUM_CH-1:0]    done_i,
    input logic [31:0]          irq_ctrl_o,
    input logic                 irq_req_o,
    input logic [31:0]          enable_o,
    input logic [NUM_CH-1:0]    ch_start_o,
    input logic [NUM_CH*32-1:0] chan_ctrl_o
);

    assert_sent_tracks_due_R5: assert property (@(posedge clk) disable iff (rst)
        irq_ctrl_o[SENT_BIT] == ((irq_ctrl_o[GEN_BIT] && (|irq_ctrl_o[30:24])) || irq_ctrl_o[BERR_BIT]));

    assert_req_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> (irq_ctrl_o[SENT_BIT] && !$past(irq_ctrl_o[SENT_BIT])));

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(OFS_CTRL)) |=>
        ((irq_ctrl_o & CTRL_LOAD_MASK) == ($past(wr_data) & CTRL_LOAD_MASK)));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assert_start_cause_R7: assert property (@(posedge clk) disable iff (rst)
            ch_start_o[n] |-> $past(wr_en && wr_addr == ADDR_W'(chan_ofs(n))
                                    && wr_data[ARM_BIT] && enable_o[CHEN_LSB + CHEN_STEP*n]));

        assert_flag_gate_R4: assert property (@(posedge clk) disable iff (rst)
            (irq_ctrl_o[FLAG_LSB+n] && !$past(irq_ctrl_o[FLAG_LSB+n]))
            |-> ($past(done_i[n]) && irq_ctrl_o[IEN_LSB+n]));

        assert_arm_clear_R9: assert property (@(posedge clk) disable iff (rst)
            (done_i[n] && !(wr_en && wr_addr == ADDR_W'(chan_ofs(n))))
            |=> !chan_ctrl_o[n*32 + ARM_BIT]);
    end

endmodule

bind dmaic_top dmaic_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .done_i      (done_i),
    .irq_ctrl_o  (irq_ctrl_o),
    .irq_req_o   (irq_req_o),
    .enable_o    (enable_o),
    .ch_start_o  (ch_start_o),
    .chan_ctrl_o (chan_ctrl_o)
);

// File: tb/dmaic_top_tb_top.sv
`timescale 1ns/1ps
module dmaic_top_tb_top;

    localparam int NCH = 7;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [11:0]    wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [NCH-1:0] done_i = '0;
    logic [31:0]    irq_ctrl_o;
    logic           irq_req_o;
    logic [31:0]    enable_o;
    logic [NCH-1:0] ch_start_o;
    logic [NCH*32-1:0] chan_ctrl_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Bench model state
    logic [31:0]    m_ctrl = '0;
    logic [31:0]    m_en   = '0;
    logic [31:0]    m_chan [NCH];
    logic           e_req  = 1'b0;
    logic [NCH-1:0] e_start = '0;

    always #2 clk = ~clk;

    dmaic_top #(.NUM_CH(NCH), .ADDR_W(12)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done_i(done_i), .irq_ctrl_o(irq_ctrl_o), .irq_req_o(irq_req_o),
        .enable_o(enable_o), .ch_start_o(ch_start_o), .chan_ctrl_o(chan_ctrl_o)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "ctrl", irq_ctrl_o, m_ctrl);
        check(tag, "req", 32'(irq_req_o), 32'(e_req));
        check(tag, "enable", enable_o, m_en);
        check(tag, "start", 32'(ch_start_o), 32'(e_start));
        for (int n = 0; n < NCH; n++) begin
            check(tag, $sformatf("chan%0d", n), chan_ctrl_o[n*32 +: 32], m_chan[n]);
        end
    endtask

    // Expected next state, computed from the requirements
    task automatic model(input bit we, input logic [11:0] a, input logic [31:0] d, input logic [NCH-1:0] dn);
        logic [31:0] b;
        bit due;
        b = m_ctrl;
        if (we && a == 12'h0F4) b = (d & 32'h00FF803F) | (m_ctrl & ~d & 32'h7F000000); // R2 R3
        for (int n = 0; n < NCH; n++) if (dn[n] && b[16+n]) b[24+n] = 1'b1;          // R4
        due = (b[23] && (|b[30:24])) || b[15];                                        // R5
        e_req = due && !m_ctrl[31];                                                   // R6
        b[31] = due;
        m_ctrl = b;
        e_start = '0;
        for (int n = 0; n < NCH; n++) begin
            if (we && a == 12'h088 + 12'(16*n)) begin
                e_start[n] = d[24] && m_en[3+4*n];                                     // R7 R8
                m_chan[n] = d;
            end else if (dn[n]) begin
                m_chan[n][24] = 1'b0;                                                  // R9
            end
        end
        if (we && a == 12'h0F0) m_en = d;                                             // R10
    endtask

    task automatic op(input bit we, input logic [11:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] dn, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; done_i = dn;
        model(we, a, d, dn);
        @(negedge clk);
        wr_en = 1'b0; done_i = '0;
        check_all(tag);
    endtask

    initial begin
        for (int n = 0; n < NCH; n++) m_chan[n] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R2 masked load, R5/R6 via all-ones (global and bus error set)
        op(1, 12'h0F4, 32'hFFFFFFFF, '0, "R2");
        op(1, 12'h0F4, 32'h12345678, '0, "R2");
        op(1, 12'h0F4, 32'hA5A5A5A5, '0, "R2");
        op(1, 12'h0F4, 32'h0000003F, '0, "R2");
        op(1, 12'h0F4, 32'h00000000, '0, "R2");

        // R10 unmapped offsets ignored
        op(1, 12'h0F8, 32'hFFFFFFFF, '0, "R10");
        op(1, 12'h08C, 32'hFFFFFFFF, '0, "R10");
        op(1, 12'h0F0, 32'h0F0F0F0F, '0, "R10");

        // R3 sweep of every clear pattern, R4 re-arming all flags
        op(1, 12'h0F4, 32'h007F0000, '0, "R4");
        op(0, 12'h000, 32'h0, 7'h7F, "R4");
        for (int p = 0; p < 128; p++) begin
            op(1, 12'h0F4, (32'(p) << 24) | 32'h007F0000, '0, "R3");
            op(0, 12'h000, 32'h0, 7'h7F, "R4");
        end

        // R4 gating by per-channel enable
        op(1, 12'h0F4, 32'h7F550000, '0, "R4");
        op(0, 12'h000, 32'h0, 7'h7F, "R4");

        // R5/R6 global enable and already-sent behaviour
        op(1, 12'h0F4, 32'h00D50000, '0, "R6");
        op(0, 12'h000, 32'h0, 7'h7F, "R6");
        op(1, 12'h0F4, 32'h7FD50000, '0, "R5");
        op(0, 12'h000, 32'h0, 7'h01, "R6");
        op(1, 12'h0F4, 32'h7F008000, '0, "R5");
        op(1, 12'h0F4, 32'h00008000, '0, "R6");
        op(1, 12'h0F4, 32'h00000000, '0, "R5");

        // R7/R8/R9 channel starts over every channel, arm value and enable state
        op(1, 12'h0F4, 32'h007F0000, '0, "R4");
        for (int en = 0; en < 2; en++) begin
            for (int n = 0; n < NCH; n++) begin
                for (int b = 0; b < 2; b++) begin
                    op(1, 12'h0F0, (en != 0) ? (32'h1 << (3+4*n)) : ~(32'h1 << (3+4*n)), '0, "R10");
                    op(1, 12'h088 + 12'(16*n), (32'(b) << 24) | 32'(n*257 + 5), '0,
                       (en != 0 && b != 0) ? "R7" : "R8");
                    op(0, 12'h000, 32'h0, 7'(1 << n), "R9");
                end
            end
        end
        op(1, 12'h0F4, 32'h7F000000, '0, "R3");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule